// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the control side of an in-order integer pipeline with stages for fetch, decode with register read, execute, memory access and writeback. It can also have a sixth stage that commits a second destination register, such as a base-register update. Every instruction in flight may write two registers: a primary one and a second one. The block owns the valid bit of every stage from decode onward. Each cycle it compares the source registers of the instructions in decode and execute against the destinations of the older instructions. From that comparison it produces three things: the operand-mux selects for execute, a one-cycle load-use stall that inserts a bubble, and a squash of wrong-path instructions when a branch in execute resolves taken.

The datapath sends register numbers, write enables, load flags and flag-set flags for each stage. It uses the valid vector from this block to gate every architectural write. The instruction and data memories both read on a clock edge. Loaded data therefore exists only at the end of the memory stage, and a consumer directly behind a load must wait one cycle. Every other result is forwarded to execute without waiting.

Top module: `hzd_ctrl`

## Requirements
- R1: Operand select values are: 0 = register file, 1 + 2*s + p for a forwarding source in stage s (memory = 0, writeback = 1, sixth stage = 2) on write port p (primary = 0, second = 1). A select is driven for each execute source register that matches that destination.
- R2: When several older writers match, the youngest stage wins (memory, then writeback, then sixth stage). Within one stage, the primary port beats the second port.
- R3: A destination acts as a forwarding source only while its stage valid bit and that port's write enable are both high.
- R4: Register 31 is the zero register. A source of 31 always selects 0, so it is never forwarded and never causes a load-use stall.
- R5: Flag select is 0 = architectural flags, 1 = memory, 2 = writeback, 3 = sixth stage. It picks the youngest valid flag-setting stage, and only while the execute instruction uses flags. Otherwise it is 0.
- R6: The stall outputs assert when four conditions all hold: a valid load in execute has its primary write enabled, its destination is not register 31, and it matches either source of a valid decode instruction. The stall outputs are fetch stall, decode stall and execute bubble.
- R7: After a stall cycle, the decode valid bit keeps its value and the execute valid bit is 0.
- R8: A taken branch signal while execute is valid raises flush_o. In the next cycle the decode and execute valid bits are 0, while the branch itself moves on to memory.
- R9: Flush takes priority over a load-use stall in the same cycle: no stall output asserts, and the decode valid bit is cleared, not held.
- R10: While rst_n is low, all stage valid bits are 0 and no select, stall or flush output is asserted.
- R11: Without a stall or flush, the valid bits shift one stage per cycle: fetch valid to decode, decode to execute, execute to memory, memory to writeback, writeback to the sixth stage. The stage valid vector uses bit 0 = decode, 1 = execute, 2 = memory, 3 = writeback, 4 = sixth stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fe_vld_i | input | 1 | Fetch holds a valid instruction that enters decode |
| br_taken_i | input | 1 | Branch in execute resolved taken |
| id_src_a_i | input | 5 | Decode first source register |
| id_src_b_i | input | 5 | Decode second source register |
| ex_src_a_i | input | 5 | Execute first source register |
| ex_src_b_i | input | 5 | Execute second source register |
| ex_flag_use_i | input | 1 | Execute instruction reads condition flags |
| ex_dst_i | input | 5 | Execute primary destination |
| ex_we_i | input | 1 | Execute primary write enable |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_dst_i | input | 2x5 | Memory stage destinations, index = port |
| mem_we_i | input | 2 | Memory stage write enables, index = port |
| mem_fset_i | input | 1 | Memory stage sets flags |
| wb_dst_i | input | 2x5 | Writeback destinations |
| wb_we_i | input | 2 | Writeback write enables |
| wb_fset_i | input | 1 | Writeback sets flags |
| s6_dst_i | input | 2x5 | Sixth stage destinations |
| s6_we_i | input | 2 | Sixth stage write enables |
| s6_fset_i | input | 1 | Sixth stage sets flags |
| fwd_a_o | output | 3 | Execute operand A select |
| fwd_b_o | output | 3 | Execute operand B select |
| fwd_f_o | output | 2 | Execute flag select |
| stall_fe_o | output | 1 | Hold the fetch register |
| stall_id_o | output | 1 | Hold the decode register |
| bubble_ex_o | output | 1 | Load a bubble into execute |
| flush_o | output | 1 | Squash the instructions in fetch and decode |
| stg_vld_o | output | 5 | Stage valid bits |

## Verification
A load-use stall and a taken-branch flush can both fall in the same cycle. The bench provokes this by placing a valid load in execute whose destination matches a decode source while it asserts br_taken_i. It then judges two things. In that cycle flush_o must be high and every stall output low. After the edge, the decode valid bit must be cleared rather than held. Forwarding from three stages and two ports can also hit the same register in one cycle, and stacked-match vectors test the priority order.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned NPORT = 2;             // write ports per instruction
  localparam int unsigned NSRCSTG = 3;           // memory, writeback, sixth stage
  localparam int unsigned NCAND = NPORT * NSRCSTG;
  localparam int unsigned SELW = $clog2(NCAND + 1);
  localparam int unsigned FSELW = $clog2(NSRCSTG + 1);
  localparam int unsigned NVLD = 5;              // decode .. sixth stage

  typedef enum logic [2:0] {
    V_ID = 3'd0,
    V_EX = 3'd1,
    V_MEM = 3'd2,
    V_WB = 3'd3,
    V_S6 = 3'd4
  } vld_idx_e;
endpackage

// File: rtl/hzd_prio_pick.sv
module hzd_prio_pick #(
  parameter int unsigned N = 6,
  parameter int unsigned OW = 3
) (
  input  logic [N-1:0]  hit_i,
  output logic [OW-1:0] sel_o
);
  // lowest index is highest priority; result is index + 1, zero when none
  always_comb begin
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) sel_o = OW'(i + 1);
    end
  end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl #(
  parameter int unsigned RW = 5,
  parameter bit HAS_ZERO = 1'b1,
  parameter logic [RW-1:0] ZREG = '1
) (
  input  logic          id_v_i,
  input  logic          ex_v_i,
  input  logic [RW-1:0] id_src_a_i,
  input  logic [RW-1:0] id_src_b_i,
  input  logic [RW-1:0] ex_dst_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic          br_taken_i,
  output logic          stall_o,
  output logic          flush_o
);
  logic dst_real;
  logic dep_hit;
  logic load_use;

  always_comb begin
    dst_real = !(HAS_ZERO && (ex_dst_i == ZREG));
    dep_hit  = (ex_dst_i == id_src_a_i) || (ex_dst_i == id_src_b_i);
    load_use = id_v_i && ex_v_i && ex_load_i && ex_we_i && dst_real && dep_hit;
    flush_o  = ex_v_i && br_taken_i;
    // the stalled decode instruction is wrong-path when a flush is present
    stall_o  = load_use && !flush_o;
  end
endmodule

// File: rtl/hzd_vld_pipe.sv
module hzd_vld_pipe
  import hzd_pkg::*;
#(
  parameter bit SIX_STAGE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fe_vld_i,
  input  logic            stall_i,
  input  logic            flush_i,
  output logic [NVLD-1:0] vld_o
);
  logic [NVLD-1:0] vld_q;
  logic [NVLD-1:0] vld_d;

  always_comb begin
    vld_d = '0;
    if (flush_i) begin
      vld_d[V_ID] = 1'b0;
      vld_d[V_EX] = 1'b0;
    end else if (stall_i) begin
      vld_d[V_ID] = vld_q[V_ID];
      vld_d[V_EX] = 1'b0;
    end else begin
      vld_d[V_ID] = fe_vld_i;
      vld_d[V_EX] = vld_q[V_ID];
    end
    vld_d[V_MEM] = vld_q[V_EX];
    vld_d[V_WB]  = vld_q[V_MEM];
  end

  generate
    if (SIX_STAGE) begin : g_six
      always_comb vld_d_s6 = vld_q[V_WB];
    end else begin : g_five
      always_comb vld_d_s6 = 1'b0;
    end
  endgenerate

  logic vld_d_s6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= {vld_d_s6, vld_d[NVLD-2:0]};
    end
  end

  assign vld_o = vld_q;

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!vld_q[V_ID] && !vld_q[V_EX]));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !flush_i) |=> (!vld_q[V_EX] && (vld_q[V_ID] == $past(vld_q[V_ID]))));

  a_r11_ex_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q[V_EX] |=> vld_q[V_MEM]);
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned RW = 5,
  parameter bit SIX_STAGE = 1'b1,
  parameter bit HAS_ZERO = 1'b1,
  parameter logic [RW-1:0] ZREG = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fe_vld_i,
  input  logic                     br_taken_i,
  input  logic [RW-1:0]            id_src_a_i,
  input  logic [RW-1:0]            id_src_b_i,
  input  logic [RW-1:0]            ex_src_a_i,
  input  logic [RW-1:0]            ex_src_b_i,
  input  logic                     ex_flag_use_i,
  input  logic [RW-1:0]            ex_dst_i,
  input  logic                     ex_we_i,
  input  logic                     ex_load_i,
  input  logic [NPORT-1:0][RW-1:0] mem_dst_i,
  input  logic [NPORT-1:0]         mem_we_i,
  input  logic                     mem_fset_i,
  input  logic [NPORT-1:0][RW-1:0] wb_dst_i,
  input  logic [NPORT-1:0]         wb_we_i,
  input  logic                     wb_fset_i,
  input  logic [NPORT-1:0][RW-1:0] s6_dst_i,
  input  logic [NPORT-1:0]         s6_we_i,
  input  logic                     s6_fset_i,
  output logic [SELW-1:0]          fwd_a_o,
  output logic [SELW-1:0]          fwd_b_o,
  output logic [FSELW-1:0]         fwd_f_o,
  output logic                     stall_fe_o,
  output logic                     stall_id_o,
  output logic                     bubble_ex_o,
  output logic                     flush_o,
  output logic [NVLD-1:0]          stg_vld_o
);
  logic [NVLD-1:0]  vld;
  logic             stall;
  logic             flush;
  logic [NSRCSTG-1:0]                    src_v;
  logic [NSRCSTG-1:0]                    src_fs;
  logic [NSRCSTG-1:0][NPORT-1:0][RW-1:0] src_dst;
  logic [NSRCSTG-1:0][NPORT-1:0]         src_we;
  logic [NCAND-1:0]   hit_a;
  logic [NCAND-1:0]   hit_b;
  logic [NSRCSTG-1:0] hit_f;
  logic               a_live;
  logic               b_live;

  hzd_vld_pipe #(.SIX_STAGE(SIX_STAGE)) u_vld (
    .clk     (clk),
    .rst_n   (rst_n),
    .fe_vld_i(fe_vld_i),
    .stall_i (stall),
    .flush_i (flush),
    .vld_o   (vld)
  );

  hzd_stall_ctl #(.RW(RW), .HAS_ZERO(HAS_ZERO), .ZREG(ZREG)) u_stall (
    .id_v_i    (vld[V_ID]),
    .ex_v_i    (vld[V_EX]),
    .id_src_a_i(id_src_a_i),
    .id_src_b_i(id_src_b_i),
    .ex_dst_i  (ex_dst_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .br_taken_i(br_taken_i),
    .stall_o   (stall),
    .flush_o   (flush)
  );

  // source stages ordered youngest first
  always_comb begin
    src_v   = {vld[V_S6], vld[V_WB], vld[V_MEM]};
    src_fs  = {s6_fset_i, wb_fset_i, mem_fset_i};
    src_dst = {s6_dst_i, wb_dst_i, mem_dst_i};
    src_we  = {s6_we_i, wb_we_i, mem_we_i};
    a_live  = !(HAS_ZERO && (ex_src_a_i == ZREG));
    b_live  = !(HAS_ZERO && (ex_src_b_i == ZREG));
  end

  generate
    for (genvar s = 0; s < NSRCSTG; s++) begin : g_stg
      for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int unsigned IDX = s * NPORT + p;
        always_comb begin
          hit_a[IDX] = a_live && src_v[s] && src_we[s][p] && (src_dst[s][p] == ex_src_a_i);
          hit_b[IDX] = b_live && src_v[s] && src_we[s][p] && (src_dst[s][p] == ex_src_b_i);
        end
      end
      always_comb hit_f[s] = ex_flag_use_i && src_v[s] && src_fs[s];
    end
  endgenerate

  hzd_prio_pick #(.N(NCAND), .OW(SELW)) u_pick_a (.hit_i(hit_a), .sel_o(fwd_a_o));
  hzd_prio_pick #(.N(NCAND), .OW(SELW)) u_pick_b (.hit_i(hit_b), .sel_o(fwd_b_o));
  hzd_prio_pick #(.N(NSRCSTG), .OW(FSELW)) u_pick_f (.hit_i(hit_f), .sel_o(fwd_f_o));

  assign stall_fe_o  = stall;
  assign stall_id_o  = stall;
  assign bubble_ex_o = stall;
  assign flush_o     = flush;
  assign stg_vld_o   = vld;

  a_r4_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_ZERO && (ex_src_a_i == ZREG)) |-> (fwd_a_o == '0));

  a_r3_mem_live: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_a_o == SELW'(1)) || (fwd_a_o == SELW'(2))) |-> stg_vld_o[V_MEM]);

  a_r9_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (!stall_id_o && !bubble_ex_o));

  a_r6_bubble_src: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex_o |-> (ex_load_i && stg_vld_o[V_EX] && stg_vld_o[V_ID]));
endmodule

// File: tb/hzd_ctrl_bench.sv
module hzd_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic fe_vld, br;
  logic [4:0] ia, ib, ea, eb, ed;
  logic fuse, ewe, eld;
  logic [1:0][4:0] mdst, wdst, sdst;
  logic [1:0] mwe, wwe, swe;
  logic mfs, wfs, sfs;
  logic [2:0] fa, fb;
  logic [1:0] ff;
  logic sfe, sid, bub, fl;
  logic [4:0] vld;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  hzd_ctrl u_hzd_ctrl (
    .clk(clk), .rst_n(rst_n), .fe_vld_i(fe_vld), .br_taken_i(br),
    .id_src_a_i(ia), .id_src_b_i(ib), .ex_src_a_i(ea), .ex_src_b_i(eb),
    .ex_flag_use_i(fuse), .ex_dst_i(ed), .ex_we_i(ewe), .ex_load_i(eld),
    .mem_dst_i(mdst), .mem_we_i(mwe), .mem_fset_i(mfs),
    .wb_dst_i(wdst), .wb_we_i(wwe), .wb_fset_i(wfs),
    .s6_dst_i(sdst), .s6_we_i(swe), .s6_fset_i(sfs),
    .fwd_a_o(fa), .fwd_b_o(fb), .fwd_f_o(ff),
    .stall_fe_o(sfe), .stall_id_o(sid), .bubble_ex_o(bub), .flush_o(fl),
    .stg_vld_o(vld)
  );

  typedef struct packed {
    logic [4:0] ia, ib, ea, eb;
    logic fuse;
    logic [4:0] ed;
    logic ewe, eld, br;
    logic [4:0] m0, m1; logic [1:0] mwe; logic mfs;
    logic [4:0] w0, w1; logic [1:0] wwe; logic wfs;
    logic [4:0] s0, s1; logic [1:0] swe; logic sfs;
    logic [2:0] xa, xb; logic [1:0] xf; logic xst, xfl;
  } row_t;

  localparam int NROW = 18;
  localparam row_t TBL [NROW] = '{
    '{1,2,1,2,0,0,0,0,0, 3,4,3,0, 5,6,3,0, 7,8,3,0, 0,0,0,0,0},
    '{1,2,3,4,0,0,0,0,0, 3,4,3,0, 5,6,3,0, 7,8,3,0, 1,2,0,0,0},
    '{1,2,5,8,0,0,0,0,0, 3,4,3,0, 5,6,3,0, 7,8,3,0, 3,6,0,0,0},
    '{1,2,9,10,0,0,0,0,0, 3,9,3,0, 9,10,3,0, 10,8,3,0, 2,4,0,0,0},
    '{1,2,11,12,0,0,0,0,0, 11,11,3,0, 5,6,3,0, 12,12,3,0, 1,5,0,0,0},
    '{1,2,13,14,0,0,0,0,0, 13,14,0,0, 13,14,1,0, 7,14,1,0, 3,0,0,0,0},
    '{1,2,31,31,0,0,0,0,0, 31,4,3,0, 31,31,3,0, 31,31,3,0, 0,0,0,0,0},
    '{1,2,1,2,1,0,0,0,0, 3,4,3,0, 5,6,3,1, 7,8,3,1, 0,0,2,0,0},
    '{1,2,1,2,1,0,0,0,0, 3,4,3,1, 5,6,3,1, 7,8,3,1, 0,0,1,0,0},
    '{1,2,1,2,0,0,0,0,0, 3,4,3,1, 5,6,3,1, 7,8,3,1, 0,0,0,0,0},
    '{1,2,1,2,1,0,0,0,0, 3,4,3,0, 5,6,3,0, 7,8,3,1, 0,0,3,0,0},
    '{20,2,1,2,0,20,1,1,0, 3,4,3,0, 5,6,3,0, 7,8,3,0, 0,0,0,1,0},
    '{1,21,1,2,0,21,1,1,0, 3,4,3,0, 5,6,3,0, 7,8,3,0, 0,0,0,1,0},
    '{31,2,1,2,0,31,1,1,0, 3,4,3,0, 5,6,3,0, 7,8,3,0, 0,0,0,0,0},
    '{20,2,1,2,0,20,1,0,0, 3,4,3,0, 5,6,3,0, 7,8,3,0, 0,0,0,0,0},
    '{20,2,1,2,0,20,0,1,0, 3,4,3,0, 5,6,3,0, 7,8,3,0, 0,0,0,0,0},
    '{1,2,1,2,0,0,0,0,1, 3,4,3,0, 5,6,3,0, 7,8,3,0, 0,0,0,0,1},
    '{20,2,1,2,0,20,1,1,1, 3,4,3,0, 5,6,3,0, 7,8,3,0, 0,0,0,0,1}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input row_t r);
    ia = r.ia; ib = r.ib; ea = r.ea; eb = r.eb; fuse = r.fuse;
    ed = r.ed; ewe = r.ewe; eld = r.eld; br = r.br;
    mdst = {r.m1, r.m0}; mwe = r.mwe; mfs = r.mfs;
    wdst = {r.w1, r.w0}; wwe = r.wwe; wfs = r.wfs;
    sdst = {r.s1, r.s0}; swe = r.swe; sfs = r.sfs;
  endtask

  // benign inputs, valid instructions fed until every stage is full
  task automatic prime();
    apply(TBL[0]);
    fe_vld = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    fe_vld = 1'b1;
    apply(TBL[1]);
    br = 1'b1; eld = 1'b1; ewe = 1'b1; ed = 5'd1; ia = 5'd1;
    repeat (3) @(negedge clk);
    // R10: reset holds everything quiet even with matching inputs
    check("R10 vld in reset", vld, 0);
    check("R10 fwd_a in reset", fa, 0);
    check("R10 stall/flush in reset", {sfe, sid, bub, fl}, 0);
    rst_n = 1'b1;
    fe_vld = 1'b0;
    repeat (3) @(negedge clk);
    // R3: no valid producers, no forwarding
    check("R3 fwd_a no valid", fa, 0);
    check("R3 fwd_b no valid", fb, 0);
    // R11: single instruction walks the stages
    apply(TBL[0]);
    fe_vld = 1'b1;
    @(negedge clk);
    fe_vld = 1'b0;
    check("R11 vld step0", vld, 5'b00001);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R11 vld step", vld, (k < 5) ? (1 << k) : 0);
    end
    // table of rows
    for (int i = 0; i < NROW; i++) begin
      prime();
      apply(TBL[i]);
      #1;
      check("R1 R2 R3 R4 fwd_a", fa, TBL[i].xa);
      check("R1 R2 R3 R4 fwd_b", fb, TBL[i].xb);
      check("R5 fwd_f", ff, TBL[i].xf);
      check("R6 R9 stall", {sfe, sid, bub}, {3{TBL[i].xst}});
      check("R8 flush", fl, TBL[i].xfl);
      @(negedge clk);
    end
    // R7: stall holds decode and bubbles execute
    prime();
    apply(TBL[11]);
    fe_vld = 1'b0;
    @(negedge clk);
    check("R7 vld after stall", vld, 5'b11101);
    apply(TBL[0]);
    @(negedge clk);
    check("R7 vld after release", vld, 5'b11010);
    // R8: flush clears decode and execute
    prime();
    apply(TBL[16]);
    @(negedge clk);
    check("R8 vld after flush", vld, 5'b11100);
    // R9: flush with load-use, decode not held
    prime();
    apply(TBL[17]);
    #1;
    check("R9 no stall under flush", {sfe, sid, bub, fl}, 4'b0001);
    @(negedge clk);
    check("R9 vld after flush+stall", vld, 5'b11100);
    finish_run();
  end
endmodule